// File: doc/BRIEF.md
# SPI Status and Interrupt-Request Register

This block holds the status word and drives the interrupt request of an SPI peripheral. A separate shift engine, which runs as master or slave, reports to it through one-cycle strobes: character done, overrun and mode-fault collision. It also reports its transmit-busy level, a per-bit sample strobe and the live active-low slave-select level. Software reads the 8-bit status word on a simple register bus and clears the event bits by writing ones to them.

In slave mode the block counts the bits sampled while slave select is low, against a configured character length. If slave select rises partway through a character, the block flags a slave abort. An abort also counts as a completed transaction and raises the interrupt request. While the peripheral enable is low, every status bit is held at its reset value and no event is recorded.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset the status word reads 0x01 and `irq_o` is 0.
- R2: Status bits 3 and 2 always read 0.
- R3: Writing 1 to any of status bits 7 (interrupt request), 6 (overrun), 5 (collision) or 4 (slave abort) clears that bit at the write edge. Writing 0 leaves it unchanged. Writes to bits 3:0 have no effect.
- R4: If a set event and a write-1-to-clear of the same bit fall on the same clock edge, the bit ends up set.
- R5: While enabled, bit 7 sets on the edge that samples `start_req_i` or `char_done_i` high.
- R6: While `en_i` is 0, the status word reads 0x01 one cycle later. Strobes and writes leave it at 0x01, and bit 7 does not set.
- R7: Bit 6 sets on a one-cycle `ovr_i` strobe and bit 5 sets on a one-cycle `col_i` strobe. Each stays set until cleared by software or by disabling.
- R8: In slave mode, suppose slave select rises while the count of bits sampled since the last whole character is between 1 and L−1. L is `char_len_i`, and a value of 0 means 8. Then bit 4 and bit 7 both set at that edge.
- R9: No abort is flagged when slave select rises after a whole number of characters, or when the block is in master mode. The bit count restarts whenever slave select is high.
- R10: Bit 1 shows `tx_busy_i` and bit 0 shows `ss_n_i`, each as sampled at the previous clock edge while enabled.
- R11: `irq_o` equals status bit 7 delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Peripheral enable |
| slave_i | input | 1 | 1 = slave mode, 0 = master mode |
| start_req_i | input | 1 | Start request from control, raises interrupt request |
| char_len_i | input | 3 | Bits per character, 0 means 8 |
| char_done_i | input | 1 | Transaction complete strobe from the shift engine |
| ovr_i | input | 1 | Overrun strobe |
| col_i | input | 1 | Mode-fault collision strobe |
| tx_busy_i | input | 1 | Transmit in progress level |
| ss_n_i | input | 1 | Live slave-select level, active low, already synchronous |
| bit_i | input | 1 | One strobe per bit sampled by the shift engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data, ones clear bits 7:4 |
| rd_data_o | output | 8 | Status word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `ss_n_i` and every strobe are synchronous to `clk`. They also assume that `char_len_i` holds steady during a slave transaction, so the bit count is compared against one fixed length. The stimulus changes every input only on the falling clock edge. It changes the character length only while slave select is high. Each event strobe lasts exactly one cycle unless a test holds it deliberately.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int STAT_W  = 8;
    localparam int LEN_W   = 3;
    localparam int STICKY_N = 4;
    // Bit positions that software decodes
    localparam int B_IRQ = 7;
    localparam int B_OVR = 6;
    localparam int B_COL = 5;
    localparam int B_ABT = 4;
    localparam int B_TX  = 1;
    localparam int B_SS  = 0;
    localparam logic [STAT_W-1:0] STAT_RST = 8'h01;

    typedef struct packed {
        logic tx;
        logic ss;
    } live_t;
endpackage

// File: rtl/spi_abort_det.sv
module spi_abort_det #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             slave_i,
    input  logic             ss_n_i,
    input  logic             bit_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             abort_o
);
    localparam int MAX_BITS = 2 ** LEN_W;
    localparam int CNT_W    = $clog2(MAX_BITS) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ss_prev;
    } det_t;

    det_t st_d, st_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        need    = (len_i == '0) ? CNT_W'(MAX_BITS) : CNT_W'(len_i);
        cnt_inc = st_q.cnt + 1'b1;
        abort_o = en_i && slave_i && ss_n_i && !st_q.ss_prev && (st_q.cnt != '0);

        st_d         = st_q;
        st_d.ss_prev = ss_n_i;
        if (!en_i || ss_n_i) begin
            st_d.cnt = '0;
        end else if (bit_i && slave_i) begin
            st_d.cnt = (cnt_inc == need) ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.ss_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_w1c_bit.sv
module spi_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d, q_q;

    always_comb begin
        if (!en_i)       q_d = 1'b0;
        else if (set_i)  q_d = 1'b1;
        else if (clr_i)  q_d = 1'b0;
        else             q_d = q_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/spi_live_bits.sv
module spi_live_bits
    import spi_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  tx_busy_i,
    input  logic  ss_n_i,
    output live_t live_o
);
    live_t live_d, live_q;

    always_comb begin
        live_d.tx = en_i & tx_busy_i;
        live_d.ss = en_i ? ss_n_i : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q.tx <= 1'b0;
            live_q.ss <= 1'b1;
        end else begin
            live_q <= live_d;
        end
    end

    assign live_o = live_q;
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              slave_i,
    input  logic              start_req_i,
    input  logic [LEN_W-1:0]  char_len_i,
    input  logic              char_done_i,
    input  logic              ovr_i,
    input  logic              col_i,
    input  logic              tx_busy_i,
    input  logic              ss_n_i,
    input  logic              bit_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic                abort;
    logic [STICKY_N-1:0] set_v;
    logic [STICKY_N-1:0] clr_v;
    logic [STICKY_N-1:0] sticky_q;
    live_t               live;
    logic                irq_out_d, irq_out_q;
    logic                unused_wr_low;

    assign unused_wr_low = ^wr_data_i[B_ABT-1:0];

    spi_abort_det #(.LEN_W(LEN_W)) i_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .slave_i (slave_i),
        .ss_n_i  (ss_n_i),
        .bit_i   (bit_i),
        .len_i   (char_len_i),
        .abort_o (abort)
    );

    spi_live_bits i_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .tx_busy_i (tx_busy_i),
        .ss_n_i    (ss_n_i),
        .live_o    (live)
    );

    // Index 0..3 map to status bits 4..7
    always_comb begin
        set_v[B_IRQ-B_ABT] = start_req_i | char_done_i | abort;
        set_v[B_OVR-B_ABT] = ovr_i;
        set_v[B_COL-B_ABT] = col_i;
        set_v[0]           = abort;
        clr_v              = wr_en_i ? wr_data_i[STAT_W-1:B_ABT] : '0;
    end

    for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
        spi_w1c_bit i_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_i),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (sticky_q[g])
        );
    end

    always_comb begin
        irq_out_d = sticky_q[B_IRQ-B_ABT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_out_q <= 1'b0;
        else        irq_out_q <= irq_out_d;
    end

    assign rd_data_o = {sticky_q, 2'b00, live.tx, live.ss};
    assign irq_o     = irq_out_q;
endmodule

// File: rtl/spi_stat_irq_chk.sv
module spi_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       char_done_i,
    input logic       ovr_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       irq_o
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[3:2] == 2'b00);

    a_r6_disabled_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> rd_data_o == 8'h01);

    a_r4_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && char_done_i |=> rd_data_o[7]);

    a_r7_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && ovr_i |=> rd_data_o[6]);

    a_r3_ovr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !ovr_i && !(wr_en_i && wr_data_i[6]) |=> rd_data_o[6] == $past(rd_data_o[6]));

    a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(rd_data_o[7]));
endmodule

bind spi_stat_irq spi_stat_irq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .char_done_i (char_done_i),
    .ovr_i       (ovr_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .irq_o       (irq_o)
);

// File: tb/test_spi_stat_irq.sv
module test_spi_stat_irq;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, slave_i = 1'b0, start_req_i = 1'b0;
    logic [2:0] char_len_i = 3'd0;
    logic       char_done_i = 1'b0, ovr_i = 1'b0, col_i = 1'b0;
    logic       tx_busy_i = 1'b0, ss_n_i = 1'b1, bit_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int vectors = 0;
    int miscompares = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_stat_irq i_spi_stat_irq (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write(input logic [7:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        tick();
        wr_en_i = 1'b0; wr_data_i = 8'h00;
    endtask

    task automatic clear_all();
        write(8'hF0);
    endtask

    task automatic t_reset();
        check("R1 status after reset", rd_data_o, 8'h01);
        check("R1 irq_o after reset", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_sources();
        en_i = 1'b1; tick();
        start_req_i = 1'b1; tick(); start_req_i = 1'b0;
        check("R5 start sets irq", rd_data_o & 8'h80, 8'h80);
        clear_all();
        check("R3 clear irq", rd_data_o & 8'hF0, 8'h00);
        char_done_i = 1'b1; tick(); char_done_i = 1'b0;
        check("R5 done sets irq", rd_data_o & 8'h80, 8'h80);
        tick();
        check("R11 irq_o follows bit 7", {7'd0, irq_o}, 8'h01);
        clear_all();
    endtask

    task automatic t_sticky_w1c();
        ovr_i = 1'b1; tick(); ovr_i = 1'b0;
        col_i = 1'b1; tick(); col_i = 1'b0;
        tick(3);
        check("R7 ovr and col sticky", rd_data_o & 8'hF0, 8'h60);
        write(8'h0F);
        check("R3 write to low bits no effect", rd_data_o & 8'hF0, 8'h60);
        write(8'h40);
        check("R3 write 1 clears ovr only", rd_data_o & 8'hF0, 8'h20);
        check("R2 reserved bits zero", rd_data_o & 8'h0C, 8'h00);
        clear_all();
    endtask

    task automatic t_set_wins();
        ovr_i = 1'b1; char_done_i = 1'b1;
        wr_en_i = 1'b1; wr_data_i = 8'hF0;
        tick();
        ovr_i = 1'b0; char_done_i = 1'b0; wr_en_i = 1'b0; wr_data_i = 8'h00;
        check("R4 set wins over clear", rd_data_o & 8'hF0, 8'hC0);
        clear_all();
    endtask

    task automatic t_live();
        tx_busy_i = 1'b1; ss_n_i = 1'b0; tick();
        check("R10 live tx and ss", rd_data_o & 8'h03, 8'h02);
        tx_busy_i = 1'b0; ss_n_i = 1'b1; tick();
        check("R10 live bits return", rd_data_o & 8'h03, 8'h01);
    endtask

    task automatic slave_xfer(input logic [2:0] len, input int nbits, input logic slv);
        slave_i = slv; char_len_i = len;
        ss_n_i = 1'b0; tick();
        bit_i = 1'b1; tick(nbits); bit_i = 1'b0;
        tick();
        ss_n_i = 1'b1; tick();
    endtask

    task automatic t_abort();
        slave_xfer(3'd3, 2, 1'b1);
        check("R8 partial char aborts", rd_data_o & 8'hF0, 8'h90);
        clear_all();
        slave_xfer(3'd0, 7, 1'b1);
        check("R8 len 0 means 8, 7 bits aborts", rd_data_o & 8'hF0, 8'h90);
        clear_all();
    endtask

    task automatic t_no_abort();
        slave_xfer(3'd3, 6, 1'b1);
        check("R9 whole chars no abort", rd_data_o & 8'hF0, 8'h00);
        slave_xfer(3'd0, 8, 1'b1);
        check("R9 eight bits no abort", rd_data_o & 8'hF0, 8'h00);
        slave_xfer(3'd3, 2, 1'b0);
        check("R9 master mode no abort", rd_data_o & 8'hF0, 8'h00);
        slave_xfer(3'd3, 2, 1'b1);
        clear_all();
        slave_xfer(3'd3, 1, 1'b1);
        check("R9 count restarts after ss high", rd_data_o & 8'hF0, 8'h90);
        clear_all();
    endtask

    task automatic t_disable();
        ovr_i = 1'b1; tick(); ovr_i = 1'b0;
        en_i = 1'b0; tick();
        check("R6 disable resets status", rd_data_o, 8'h01);
        start_req_i = 1'b1; char_done_i = 1'b1; col_i = 1'b1; tx_busy_i = 1'b1; ss_n_i = 1'b0;
        tick(2);
        start_req_i = 1'b0; char_done_i = 1'b0; col_i = 1'b0; tx_busy_i = 1'b0; ss_n_i = 1'b1;
        check("R6 events ignored while disabled", rd_data_o, 8'h01);
        check("R6 irq_o stays low", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done_flag) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sources();
        t_sticky_w1c();
        t_set_wins();
        t_live();
        t_abort();
        t_no_abort();
        t_disable();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule